// File: doc/BRIEF.md
# Transmit Write Unpacker

This block converts writes to a 32-bit transmit data register into a sequence of pushes toward a transmit FIFO. The serial mode chosen at the time of the write decides which write sizes are allowed, which byte lanes a narrow write uses, how wide each pushed unit is and in what order the units leave. There are five modes: byte-oriented serial, 8-bit codec, 16-bit codec, 24-bit codec and 32-bit codec.

A write is a one-cycle strobe carrying a mode, a size code and a data word. It is taken only while the unpacker reports write-ready. A legal write is split into units. Each unit is right-aligned on the push data bus with zeros above it. The units are presented with a valid/ready handshake. A write whose size does not suit the mode pushes nothing and produces a one-cycle error pulse.

Bit numbering follows the register convention in which bit 0 is the most significant bit of the word. Bits 0:7 are therefore `wr_data_i[31:24]`.

Top module: `tx_wr_unpacker`

## Requirements
- R1: After reset, `wr_ready_o` is 1, and both `push_valid_o` and `wr_err_o` are 0.
- R2: Mode codes are 0 for byte serial, 1 for 8-bit codec, 2 for 16-bit codec, 3 for 24-bit codec and 4 for 32-bit codec. Size codes are 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes. In modes 0 and 1, all three sizes are legal and give 1, 2 or 4 byte units, each placed in `push_data_o[7:0]` with zeros in bits 31:8.
- R3: A 1-byte write takes its byte from `wr_data_i[31:24]`. A 2-byte write takes its bytes from `wr_data_i[31:16]`. Units are pushed starting from the most significant end of the word (bit 0 first).
- R4: In mode 2, only sizes 2 and 4 bytes are legal. A 2-byte write pushes `wr_data_i[31:16]`. A 4-byte write pushes `wr_data_i[31:16]` and then `wr_data_i[15:0]`. Each unit sits in `push_data_o[15:0]` with zeros above it.
- R5: In mode 3, only the 4-byte size is legal. The write pushes one unit with `push_data_o[23:0]` equal to `wr_data_i[23:0]` and bits 31:24 equal to zero.
- R6: In mode 4, only the 4-byte size is legal. The write pushes the whole word as one unit.
- R7: A strobed write with an illegal size for the mode pulses `wr_err_o` high in the next cycle only and pushes nothing. Size code 3 is always illegal, and mode codes 5 to 7 reject every size.
- R8: From the cycle after a legal write is taken until its last unit is accepted, `wr_ready_o` is 0. A strobe raised while `wr_ready_o` is 0 is ignored and pushes nothing.
- R9: While `push_valid_o` is 1 and `push_ready_i` is 0, the valid signal and `push_data_o` hold their values into the next cycle.
- R10: The mode is taken when a write is accepted. Changing `mode_i` while a sequence is in progress does not alter the remaining units.
- R11: The first unit of a legal write is valid in the cycle after the write is taken. `wr_ready_o` returns to 1 in the cycle after the last unit is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Serial mode select |
| wr_stb_i | input | 1 | Write strobe to the transmit data register |
| wr_size_i | input | 2 | Write size code |
| wr_data_i | input | 32 | Write data, bit 0 = MSB convention |
| wr_ready_o | output | 1 | Unpacker can take a write |
| wr_err_o | output | 1 | One-cycle pulse for an illegal write size |
| push_valid_o | output | 1 | A unit is offered to the FIFO |
| push_data_o | output | 32 | Offered unit, right-aligned, zero-extended |
| push_ready_i | input | 1 | FIFO accepts the offered unit |

## Verification
The checker assumes that the mode, size and data inputs are meaningful only in a cycle where the strobe meets write-ready. It also assumes that the FIFO side may withhold ready for any number of cycles. Under those assumptions it relates the push count of every sequence to the mode and size captured at acceptance. The stimulus always drives the inputs on the falling edge. It deliberately raises a stray strobe and a mode change only while a sequence is busy, so that the ignore and hold properties are exercised without ever starting an overlapping write.

// File: rtl/txu_pkg.sv
package txu_pkg;

   localparam logic [2:0] MODE_BYTE = 3'd0;
   localparam logic [2:0] MODE_C8   = 3'd1;
   localparam logic [2:0] MODE_C16  = 3'd2;
   localparam logic [2:0] MODE_C24  = 3'd3;
   localparam logic [2:0] MODE_C32  = 3'd4;

   localparam logic [1:0] SIZE_1B = 2'd0;
   localparam logic [1:0] SIZE_2B = 2'd1;
   localparam logic [1:0] SIZE_4B = 2'd2;

   // unit width in bytes minus one
   typedef enum logic [1:0] {
      UNIT_8  = 2'd0,
      UNIT_16 = 2'd1,
      UNIT_24 = 2'd2,
      UNIT_32 = 2'd3
   } txu_unit_e;

endpackage

// File: rtl/txu_decode.sv
module txu_decode
   import txu_pkg::*;
#(
   parameter int CNT_W = 3
) (
   input  logic [2:0]       mode_i,
   input  logic [1:0]       size_i,
   output logic             legal_o,
   output logic [CNT_W-1:0] units_o,
   output txu_unit_e        kind_o
);

   always_comb begin
      legal_o = 1'b0;
      units_o = '0;
      kind_o  = UNIT_8;
      case (mode_i)
         MODE_BYTE, MODE_C8: begin
            kind_o = UNIT_8;
            case (size_i)
               SIZE_1B: begin legal_o = 1'b1; units_o = CNT_W'(1); end
               SIZE_2B: begin legal_o = 1'b1; units_o = CNT_W'(2); end
               SIZE_4B: begin legal_o = 1'b1; units_o = CNT_W'(4); end
               default: ;
            endcase
         end
         MODE_C16: begin
            kind_o = UNIT_16;
            case (size_i)
               SIZE_2B: begin legal_o = 1'b1; units_o = CNT_W'(1); end
               SIZE_4B: begin legal_o = 1'b1; units_o = CNT_W'(2); end
               default: ;
            endcase
         end
         MODE_C24: begin
            kind_o = UNIT_24;
            if (size_i == SIZE_4B) begin
               legal_o = 1'b1;
               units_o = CNT_W'(1);
            end
         end
         MODE_C32: begin
            kind_o = UNIT_32;
            if (size_i == SIZE_4B) begin
               legal_o = 1'b1;
               units_o = CNT_W'(1);
            end
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/txu_shift.sv
module txu_shift
   import txu_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter int N_BYTES = 4,
   parameter int CNT_W   = 3,
   localparam int WORD_W = BYTE_W * N_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [WORD_W-1:0] data_i,
   input  logic [CNT_W-1:0]  units_i,
   input  txu_unit_e         kind_i,
   input  logic              pop_i,
   output logic              valid_o,
   output logic [WORD_W-1:0] unit_o
);

   logic [WORD_W-1:0] sh_q;
   logic [CNT_W-1:0]  left_q;
   txu_unit_e         kind_q;
   logic [WORD_W-1:0] cand [N_BYTES];

   // one right-aligned view of the top of the shift register per unit width
   for (genvar g = 0; g < N_BYTES; g++) begin : g_view
      assign cand[g] = WORD_W'(sh_q[WORD_W-1 -: (g+1)*BYTE_W]);
   end

   assign unit_o  = cand[kind_q];
   assign valid_o = (left_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         left_q <= '0;
         kind_q <= UNIT_8;
      end else if (load_i) begin
         kind_q <= kind_i;
         left_q <= units_i;
         // the 24-bit sample sits in the low lanes: lift it to the top
         sh_q   <= (kind_i == UNIT_24) ? (data_i << BYTE_W) : data_i;
      end else if (pop_i) begin
         left_q <= left_q - CNT_W'(1);
         sh_q   <= sh_q << ((int'(kind_q) + 1) * BYTE_W);
      end
   end

endmodule

// File: rtl/tx_wr_unpacker.sv
module tx_wr_unpacker
   import txu_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter int N_BYTES = 4,
   localparam int WORD_W = BYTE_W * N_BYTES,
   localparam int CNT_W  = $clog2(N_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode_i,
   input  logic              wr_stb_i,
   input  logic [1:0]        wr_size_i,
   input  logic [WORD_W-1:0] wr_data_i,
   output logic              wr_ready_o,
   output logic              wr_err_o,
   output logic              push_valid_o,
   output logic [WORD_W-1:0] push_data_o,
   input  logic              push_ready_i
);

   if (N_BYTES != 4) begin : g_bad_bytes
      $error("tx_wr_unpacker: the mode set needs a four-byte word");
   end
   if (BYTE_W < 1) begin : g_bad_width
      $error("tx_wr_unpacker: BYTE_W must be positive");
   end

   logic             accept;
   logic             legal;
   logic [CNT_W-1:0] units;
   txu_unit_e        kind;
   logic             err_q;

   assign wr_ready_o = ~push_valid_o;
   assign accept     = wr_stb_i & wr_ready_o;

   txu_decode #(.CNT_W(CNT_W)) u_dec (
      .mode_i  (mode_i),
      .size_i  (wr_size_i),
      .legal_o (legal),
      .units_o (units),
      .kind_o  (kind)
   );

   txu_shift #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES), .CNT_W(CNT_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (accept & legal),
      .data_i  (wr_data_i),
      .units_i (units),
      .kind_i  (kind),
      .pop_i   (push_valid_o & push_ready_i),
      .valid_o (push_valid_o),
      .unit_o  (push_data_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= accept & ~legal;
   end

   assign wr_err_o = err_q;

endmodule

// File: rtl/txu_chk.sv
module txu_chk
   import txu_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        mode_i,
   input logic              wr_stb_i,
   input logic [1:0]        wr_size_i,
   input logic              wr_ready_o,
   input logic              wr_err_o,
   input logic              push_valid_o,
   input logic [WORD_W-1:0] push_data_o,
   input logic              push_ready_i
);

   logic [2:0] cap_mode;
   logic [1:0] cap_size;
   logic [2:0] npush;

   function automatic logic [2:0] exp_cnt(logic [2:0] m, logic [1:0] s);
      logic [2:0] nb;
      nb = (s == SIZE_1B) ? 3'd1 : (s == SIZE_2B) ? 3'd2 : (s == SIZE_4B) ? 3'd4 : 3'd0;
      if (m == MODE_BYTE || m == MODE_C8) return nb;
      if (m == MODE_C16) return (nb == 3'd4) ? 3'd2 : (nb == 3'd2) ? 3'd1 : 3'd0;
      if (m == MODE_C24 || m == MODE_C32) return (nb == 3'd4) ? 3'd1 : 3'd0;
      return 3'd0;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_mode <= '0;
         cap_size <= '0;
         npush    <= '0;
      end else if (wr_stb_i && wr_ready_o) begin
         cap_mode <= mode_i;
         cap_size <= wr_size_i;
         npush    <= '0;
      end else if (push_valid_o && push_ready_i) begin
         npush <= npush + 3'd1;
      end
   end

   assert_units_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(push_valid_o) |-> npush == exp_cnt(cap_mode, cap_size));

   assert_narrow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid_o && (cap_mode == MODE_BYTE || cap_mode == MODE_C8))
      |-> push_data_o[WORD_W-1:BYTE_W] == '0);

   assert_c24_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid_o && cap_mode == MODE_C24) |-> push_data_o[WORD_W-1 -: BYTE_W] == '0);

   assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err_o |-> $past(wr_stb_i && wr_ready_o));

   assert_err_nopush_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err_o |-> !push_valid_o);

   assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      push_valid_o |-> !wr_ready_o);

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid_o && !push_ready_i) |=> (push_valid_o && $stable(push_data_o)));

   assert_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(push_valid_o) |-> $past(wr_stb_i && wr_ready_o));

endmodule

bind tx_wr_unpacker txu_chk #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_chk (.*);

// File: tb/sim_tx_wr_unpacker.sv
module sim_tx_wr_unpacker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  mode_i = '0;
   logic        wr_stb_i = 1'b0;
   logic [1:0]  wr_size_i = '0;
   logic [31:0] wr_data_i = '0;
   logic        wr_ready_o, wr_err_o, push_valid_o, push_ready_i;
   logic [31:0] push_data_o;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   tx_wr_unpacker u0 (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .wr_stb_i(wr_stb_i),
      .wr_size_i(wr_size_i), .wr_data_i(wr_data_i), .wr_ready_o(wr_ready_o),
      .wr_err_o(wr_err_o), .push_valid_o(push_valid_o), .push_data_o(push_data_o),
      .push_ready_i(push_ready_i)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
      end
   endtask

   // expected units from the requirements
   task automatic model(input logic [2:0] m, input logic [1:0] s, input logic [31:0] d,
                        output int n, output logic [31:0] q [4]);
      int wb, ub;
      bit ok;
      wb = (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : (s == 2'd2) ? 4 : 0;
      ub = (m <= 3'd1) ? 1 : (m == 3'd2) ? 2 : (m == 3'd3) ? 3 : 4;
      ok = (m <= 3'd4) && (wb != 0);
      if (m == 3'd2 && wb < 2) ok = 0;
      if (m >= 3'd3 && wb != 4) ok = 0;
      n = !ok ? 0 : (m == 3'd3) ? 1 : wb / ub;
      for (int k = 0; k < 4; k++) begin
         if (m == 3'd3) q[k] = {8'h00, d[23:0]};
         else if (ub == 4) q[k] = d;
         else q[k] = (d >> (32 - ub*8*(k+1))) & ((32'd1 << (ub*8)) - 32'd1);
      end
   endtask

   task automatic run_write(input logic [2:0] m, input logic [1:0] s, input logic [31:0] d,
                            input logic [15:0] stall, input bit disturb, input string req);
      int n, got;
      logic [31:0] q [4];
      logic [31:0] rec [4];
      logic [31:0] held;
      bit was_stall;
      model(m, s, d, n, q);
      got = 0;
      was_stall = 0;
      held = '0;
      for (int k = 0; k < 4; k++) rec[k] = '0;
      @(negedge clk);
      mode_i = m; wr_size_i = s; wr_data_i = d; wr_stb_i = 1'b1;
      @(negedge clk);
      wr_stb_i = 1'b0;
      #1;
      chk(wr_err_o == (n == 0), (n == 0) ? "R7" : req, "error flag", 32'(wr_err_o), 32'(n == 0));
      chk(push_valid_o == (n != 0), "R11", "first unit timing", 32'(push_valid_o), 32'(n != 0));
      for (int i = 0; i < 40; i++) begin
         push_ready_i = !stall[i % 16];
         if (disturb && i == 0) begin
            mode_i = 3'd2; wr_size_i = 2'd2; wr_data_i = 32'hDEAD_BEEF; wr_stb_i = 1'b1;
         end
         if (disturb && i == 1) wr_stb_i = 1'b0;
         #1;
         if (!push_valid_o) break;
         chk(!wr_ready_o, "R8", "ready low while busy", 32'(wr_ready_o), 32'd0);
         if (was_stall)
            chk(push_data_o == held, "R9", "data held under stall", push_data_o, held);
         was_stall = !push_ready_i;
         held = push_data_o;
         if (push_ready_i) begin
            if (got < 4) rec[got] = push_data_o;
            got++;
         end
         @(negedge clk);
      end
      chk(got == n, disturb ? "R10" : req, "unit count", 32'(got), 32'(n));
      for (int k = 0; k < 4; k++)
         if (k < n) chk(rec[k] == q[k], disturb ? "R10" : req, "unit value", rec[k], q[k]);
      chk(wr_ready_o == 1'b1, "R11", "ready after sequence", 32'(wr_ready_o), 32'd1);
      @(negedge clk);
      #1;
      chk(wr_err_o == 1'b0, "R7", "error pulse one cycle", 32'(wr_err_o), 32'd0);
      chk(push_valid_o == 1'b0, "R8", "no extra push", 32'(push_valid_o), 32'd0);
      push_ready_i = 1'b1;
   endtask

   task automatic t_reset();
      #1;
      chk(wr_ready_o == 1'b1, "R1", "reset ready", 32'(wr_ready_o), 32'd1);
      chk(push_valid_o == 1'b0, "R1", "reset valid", 32'(push_valid_o), 32'd0);
      chk(wr_err_o == 1'b0, "R1", "reset error", 32'(wr_err_o), 32'd0);
   endtask

   task automatic t_byte_modes();
      run_write(3'd0, 2'd0, 32'hA1B2_C3D4, 16'h0000, 0, "R3");
      run_write(3'd0, 2'd1, 32'hA1B2_C3D4, 16'h0000, 0, "R3");
      run_write(3'd0, 2'd2, 32'h1122_3344, 16'h0000, 0, "R2");
      run_write(3'd1, 2'd1, 32'h5566_7788, 16'h0000, 0, "R2");
   endtask

   task automatic t_stall();
      run_write(3'd1, 2'd2, 32'hCAFE_F00D, 16'h002B, 0, "R9");
      run_write(3'd2, 2'd2, 32'h1357_9BDF, 16'h0005, 0, "R9");
   endtask

   task automatic t_codec16();
      run_write(3'd2, 2'd1, 32'hBEEF_0123, 16'h0000, 0, "R4");
      run_write(3'd2, 2'd2, 32'hBEEF_0123, 16'h0000, 0, "R4");
      run_write(3'd2, 2'd0, 32'hBEEF_0123, 16'h0000, 0, "R4");
   endtask

   task automatic t_codec24();
      run_write(3'd3, 2'd2, 32'hFF12_3456, 16'h0000, 0, "R5");
      run_write(3'd3, 2'd1, 32'hFF12_3456, 16'h0000, 0, "R5");
   endtask

   task automatic t_codec32();
      run_write(3'd4, 2'd2, 32'h89AB_CDEF, 16'h0001, 0, "R6");
      run_write(3'd4, 2'd0, 32'h89AB_CDEF, 16'h0000, 0, "R6");
   endtask

   task automatic t_illegal();
      run_write(3'd5, 2'd2, 32'h0BAD_0BAD, 16'h0000, 0, "R7");
      run_write(3'd7, 2'd0, 32'h0BAD_0BAD, 16'h0000, 0, "R7");
      run_write(3'd0, 2'd3, 32'h0BAD_0BAD, 16'h0000, 0, "R7");
   endtask

   task automatic t_disturb();
      run_write(3'd1, 2'd2, 32'h0102_0304, 16'h0003, 1, "R10");
      run_write(3'd0, 2'd1, 32'hE5F6_0000, 16'h0001, 1, "R8");
   endtask

   initial begin
      push_ready_i = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_byte_modes();
      t_stall();
      t_codec16();
      t_codec24();
      t_codec32();
      t_illegal();
      t_disturb();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #1500000;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule